// File: doc/BRIEF.md
# Hot-swap I2C bus connect controller

This controller decides when the two-wire bus on a plug-in card may be tied to a live backplane bus. It covers power-up and live insertion. Power-good flags, the backplane line levels and the card line levels come in as digital inputs. The controller drives a precharge enable, a connect enable and a rise-time accelerator enable. It also outputs a logical model of the four lines as each side sees them.

After reset the block holds in a supply lockout phase with precharge on, and it ignores bus traffic there. Once power is good it assumes a transfer may already be running on the backplane. It waits for the backplane to show a STOP or to stay idle for a programmable number of cycles. It then waits until both card lines are released, and finally joins the buses. While the buses are joined, each line behaves as one wired-AND net across both sides, with SDA and SCL handled separately. Losing either supply drops the join at once and returns the block to lockout.

Top module: `hs_join_top`

## Requirements
- R1: During and right after reset, `phase` is 2'b00, `prechargeEn` is 1, and `connectEn` and `accelEn` are 0.
- R2: In phase 2'b00 the block moves to 2'b01 on the first clock at which supply is good. Supply is good when `supplyGood` is 1 and, if `NEED_SECOND` is 1, `supply2Good` is also 1. Backplane and card line activity has no effect on this phase.
- R3: `prechargeEn` is 1 exactly while `phase` is 2'b00, and it is never 1 together with `connectEn`.
- R4: All four line inputs pass through a `SYNC_STAGES`-flop synchroniser (default 2). In phase 2'b01 a STOP on the backplane moves the phase to 2'b10 on the next clock. A STOP is the synchronised backplane SDA going from 0 to 1 while the synchronised backplane SCL is 1. SDA changes while SCL is 0 do not count as a STOP.
- R5: In phase 2'b01 the phase also moves to 2'b10 after both synchronised backplane lines have been 1 for `IDLE_CYCLES` consecutive clocks (default 1000). A 0 on either line restarts that count.
- R6: In phase 2'b10 the phase moves to 2'b11 on the clock after both synchronised card lines read 1. No new STOP is needed, however long the card lines were held low.
- R7: `connectEn` and `accelEn` are always equal. They are 1 exactly when `phase` is 2'b11 and supply is good.
- R8: Line inputs and outputs use 1 for released and 0 for pulled low. While `connectEn` is 1, SDA on both sides is the AND of the backplane and card SDA inputs. SCL on both sides is likewise the AND of the two SCL inputs, independently of SDA. While `connectEn` is 0, each side's output follows its own input.
- R9: If supply stops being good in any phase, `connectEn` and `accelEn` fall combinationally in the same cycle, and `phase` is 2'b00 after the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyGood | input | 1 | Main supply good flag |
| supply2Good | input | 1 | Second supply good flag (used when NEED_SECOND=1) |
| bpSdaIn | input | 1 | Backplane SDA driver level, 0 = pulled low |
| bpSclIn | input | 1 | Backplane SCL driver level, 0 = pulled low |
| cdSdaIn | input | 1 | Card SDA driver level, 0 = pulled low |
| cdSclIn | input | 1 | Card SCL driver level, 0 = pulled low |
| prechargeEn | output | 1 | Precharge enable, on during lockout |
| connectEn | output | 1 | Bus join enable |
| accelEn | output | 1 | Rise-time accelerator enable |
| bpSdaLine | output | 1 | Resolved backplane SDA level |
| bpSclLine | output | 1 | Resolved backplane SCL level |
| cdSdaLine | output | 1 | Resolved card SDA level |
| cdSclLine | output | 1 | Resolved card SCL level |
| phase | output | 2 | 00 lockout, 01 wait STOP/idle, 10 wait card high, 11 joined |

## Verification
The assertions assume that the supply flags are synchronous to `clk`. They also assume the line inputs may change on any clock, but only their synchronised copies drive the phase decisions. The bench changes every input half a period away from the active edge, so each input is stable at the sampling edge. It holds reset over several clocks before releasing it. STOP events are built from SCL already high for several cycles, so the synchroniser always sees SCL high before SDA rises.

// File: rtl/hs_join_pkg.sv
package hs_join_pkg;
  typedef enum logic [1:0] {
    PH_LOCK = 2'b00,
    PH_WAIT = 2'b01,
    PH_CARD = 2'b10,
    PH_CONN = 2'b11
  } phase_e;

  // control -> datapath
  typedef struct packed {
    logic clrIdle;
    logic joinLines;
  } ctrl_strobe_t;

  // datapath -> control
  typedef struct packed {
    logic stopSeen;
    logic idleSeen;
    logic cardHigh;
  } bus_status_t;
endpackage

// File: rtl/hs_join_datapath.sv
module hs_join_datapath
  import hs_join_pkg::*;
#(
  parameter int IDLE_CYCLES = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [3:0]   rawLines,   // [0] bp SDA, [1] bp SCL, [2] card SDA, [3] card SCL
  input  ctrl_strobe_t strobe,
  output bus_status_t  status,
  output logic [1:0]   bpLevel,    // [0] SDA, [1] SCL
  output logic [1:0]   cdLevel
);
  localparam int CNT_W    = $clog2(IDLE_CYCLES + 1);
  localparam int N_LINES  = 4;
  localparam int N_WIRES  = N_LINES / 2;

  logic [N_LINES-1:0] synced;
  logic               sdaPrev;
  logic [CNT_W-1:0]   idleCnt;
  logic               bpBothHigh;

  genvar g;
  for (g = 0; g < N_LINES; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[SYNC_STAGES-2:0], rawLines[g]};
    end
    assign synced[g] = chain[SYNC_STAGES-1];
  end

  assign bpBothHigh = synced[0] & synced[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sdaPrev <= 1'b1;
    else       sdaPrev <= synced[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             idleCnt <= '0;
    else if (strobe.clrIdle || !bpBothHigh) idleCnt <= '0;
    else if (idleCnt != CNT_W'(IDLE_CYCLES)) idleCnt <= idleCnt + 1'b1;
  end

  assign status.stopSeen = bpBothHigh & ~sdaPrev;
  assign status.idleSeen = (idleCnt == CNT_W'(IDLE_CYCLES));
  assign status.cardHigh = synced[2] & synced[3];

  // wired-AND join per wire, SDA and SCL independent
  for (g = 0; g < N_WIRES; g++) begin : g_join
    logic wired;
    assign wired      = rawLines[g] & rawLines[g+N_WIRES];
    assign bpLevel[g] = strobe.joinLines ? wired : rawLines[g];
    assign cdLevel[g] = strobe.joinLines ? wired : rawLines[g+N_WIRES];
  end

  AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    !bpBothHigh |=> idleCnt == '0) else $error("idle count not restarted"); // R5

  AST_STOP_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rstN)
    status.stopSeen |=> !status.stopSeen) else $error("stop held two cycles"); // R4
endmodule

// File: rtl/hs_join_ctrl.sv
module hs_join_ctrl
  import hs_join_pkg::*;
#(
  parameter bit NEED_SECOND = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         supplyGood,
  input  logic         supply2Good,
  input  bus_status_t  status,
  output ctrl_strobe_t strobe,
  output logic [1:0]   phase,
  output logic         prechargeEn,
  output logic         connectEn,
  output logic         accelEn
);
  phase_e state, stateNxt;
  logic   supplyOk;

  if (NEED_SECOND) begin : g_two_supplies
    assign supplyOk = supplyGood & supply2Good;
  end else begin : g_one_supply
    assign supplyOk = supplyGood;
  end

  always_comb begin
    stateNxt = state;
    if (!supplyOk) stateNxt = PH_LOCK;
    else begin
      unique case (state)
        PH_LOCK: stateNxt = PH_WAIT;
        PH_WAIT: if (status.stopSeen || status.idleSeen) stateNxt = PH_CARD;
        PH_CARD: if (status.cardHigh) stateNxt = PH_CONN;
        PH_CONN: stateNxt = PH_CONN;
        default: stateNxt = PH_LOCK;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PH_LOCK;
    else       state <= stateNxt;
  end

  assign strobe.clrIdle   = (state == PH_LOCK);
  assign strobe.joinLines = (state == PH_CONN) & supplyOk;
  assign connectEn        = strobe.joinLines;
  assign accelEn          = strobe.joinLines;
  assign prechargeEn      = (state == PH_LOCK);
  assign phase            = state;

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_LOCK && !supplyOk) |=> state == PH_LOCK) else $error("left lockout"); // R2

  AST_EVENT_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_WAIT && supplyOk && (status.stopSeen || status.idleSeen)) |=> state == PH_CARD)
    else $error("event missed"); // R4

  AST_CARD_CONNECT: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_CARD && supplyOk && status.cardHigh) |=> state == PH_CONN)
    else $error("card high not joined"); // R6

  AST_SUPPLY_LOSS: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> (state == PH_LOCK)) else $error("no lockout on supply loss"); // R9

  AST_PRECHARGE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(prechargeEn && connectEn)) else $error("precharge with join"); // R3
endmodule

// File: rtl/hs_join_top.sv
module hs_join_top
  import hs_join_pkg::*;
#(
  parameter int IDLE_CYCLES = 1000,
  parameter int SYNC_STAGES = 2,
  parameter bit NEED_SECOND = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyGood,
  input  logic       supply2Good,
  input  logic       bpSdaIn,
  input  logic       bpSclIn,
  input  logic       cdSdaIn,
  input  logic       cdSclIn,
  output logic       prechargeEn,
  output logic       connectEn,
  output logic       accelEn,
  output logic       bpSdaLine,
  output logic       bpSclLine,
  output logic       cdSdaLine,
  output logic       cdSclLine,
  output logic [1:0] phase
);
  ctrl_strobe_t strobe;
  bus_status_t  status;
  logic [1:0]   bpLevel, cdLevel;

  hs_join_ctrl #(.NEED_SECOND(NEED_SECOND)) u_ctrl (
    .clk(clk), .rstN(rstN), .supplyGood(supplyGood), .supply2Good(supply2Good),
    .status(status), .strobe(strobe), .phase(phase), .prechargeEn(prechargeEn),
    .connectEn(connectEn), .accelEn(accelEn)
  );

  hs_join_datapath #(.IDLE_CYCLES(IDLE_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .rawLines({cdSclIn, cdSdaIn, bpSclIn, bpSdaIn}),
    .strobe(strobe), .status(status), .bpLevel(bpLevel), .cdLevel(cdLevel)
  );

  assign bpSdaLine = bpLevel[0];
  assign bpSclLine = bpLevel[1];
  assign cdSdaLine = cdLevel[0];
  assign cdSclLine = cdLevel[1];
endmodule

// File: tb/hs_join_top_tb.sv
module hs_join_top_tb;
  localparam int IDLE = 1000;
  localparam bit NEED2 = 1'b1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sg = 1'b0, sg2 = 1'b0;
  logic bpSda = 1'b1, bpScl = 1'b1, cdSda = 1'b1, cdScl = 1'b1;
  logic prechargeEn, connectEn, accelEn;
  logic bpSdaL, bpSclL, cdSdaL, cdSclL;
  logic [1:0] phase;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  hs_join_top #(.IDLE_CYCLES(IDLE), .SYNC_STAGES(2), .NEED_SECOND(NEED2)) u_dut (
    .clk(clk), .rstN(rstN), .supplyGood(sg), .supply2Good(sg2),
    .bpSdaIn(bpSda), .bpSclIn(bpScl), .cdSdaIn(cdSda), .cdSclIn(cdScl),
    .prechargeEn(prechargeEn), .connectEn(connectEn), .accelEn(accelEn),
    .bpSdaLine(bpSdaL), .bpSclLine(bpSclL), .cdSdaLine(cdSdaL), .cdSclLine(cdSclL),
    .phase(phase)
  );

  // ---------------- behavioural reference ----------------
  int mPhase = 0;
  int mCnt = 0;
  bit mPrev = 1;
  logic [3:0] hist[$] = '{4'hF, 4'hF};

  function automatic bit supplyOk();
    return sg && (sg2 || !NEED2);
  endfunction

  always @(posedge clk) begin
    if (rstN) begin
      logic [3:0] s;
      int nxt;
      bit stopEv, idleEv;
      s = hist[0];
      stopEv = s[0] && s[1] && !mPrev;
      idleEv = (mCnt == IDLE);
      nxt = mPhase;
      if (!supplyOk()) nxt = 0;
      else if (mPhase == 0) nxt = 1;
      else if (mPhase == 1 && (stopEv || idleEv)) nxt = 2;
      else if (mPhase == 2 && s[2] && s[3]) nxt = 3;
      if (mPhase == 0 || !(s[0] && s[1])) mCnt = 0;
      else if (mCnt < IDLE) mCnt++;
      mPrev = s[0];
      mPhase = nxt;
      void'(hist.pop_front());
      hist.push_back({cdScl, cdSda, bpScl, bpSda});
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every clock, away from the edge
  always @(posedge clk) begin
    #2;
    if (rstN && !finished) begin
      bit conn;
      conn = (mPhase == 3) && supplyOk();
      check("phase R2 R4 R5 R6 R9", phase, mPhase);
      check("precharge R3", prechargeEn, mPhase == 0);
      check("connectEn R7", connectEn, conn);
      check("accelEn R7", accelEn, conn);
      check("bp SDA R8", bpSdaL, conn ? (bpSda & cdSda) : bpSda);
      check("cd SDA R8", cdSdaL, conn ? (bpSda & cdSda) : cdSda);
      check("bp SCL R8", bpSclL, conn ? (bpScl & cdScl) : bpScl);
      check("cd SCL R8", cdSclL, conn ? (bpScl & cdScl) : cdScl);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(3);
    check("reset phase R1", phase, 0);
    check("reset precharge R1", prechargeEn, 1);
    check("reset connect R1", connectEn, 0);
    check("reset accel R1", accelEn, 0);
    rstN = 1'b1;
    cyc(1);
    check("post-reset phase R1", phase, 0);

    // lockout ignores bus activity, incl. STOP shapes
    for (int i = 0; i < 12; i++) begin
      bpSda = i[0]; bpScl = (i % 4) != 3;
      cyc(2);
    end
    check("lockout ignores bus R2", phase, 0);

    // only main supply good: still lockout
    bpScl = 1'b0; bpSda = 1'b0;
    sg = 1'b1;
    cyc(20);
    check("second supply needed R2", phase, 0);
    check("precharge in lockout R3", prechargeEn, 1);
    sg2 = 1'b1;
    cyc(1);
    check("leave lockout R2", phase, 1);
    check("precharge off R3", prechargeEn, 0);

    // SDA toggling with SCL low: no STOP
    for (int i = 0; i < 40; i++) begin
      bpSda = ~bpSda;
      cyc(1);
    end
    check("no stop with SCL low R4", phase, 1);

    // card SDA held low, then a STOP on the backplane
    cdSda = 1'b0;
    bpSda = 1'b0; bpScl = 1'b1;
    cyc(4);
    check("still waiting R4", phase, 1);
    bpSda = 1'b1;
    cyc(2);
    check("stop not yet through sync R4", phase, 1);
    cyc(1);
    check("stop seen R4", phase, 2);
    for (int i = 0; i < 10; i++) begin
      bpScl = ~bpScl;
      cyc(2);
    end
    bpScl = 1'b1;
    check("card low keeps waiting R6", phase, 2);
    check("not connected R7", connectEn, 0);
    cdSda = 1'b1;
    cyc(2);
    check("card high not yet synced R6", phase, 2);
    cyc(1);
    check("joined R6", phase, 3);
    check("connect on R7", connectEn, 1);
    check("accel on R7", accelEn, 1);

    // wired-AND behaviour, SDA and SCL independent
    for (int p = 0; p < 16; p++) begin
      {cdScl, cdSda, bpScl, bpSda} = 4'(p);
      #1;
      check("join SDA bp R8", bpSdaL, bpSda & cdSda);
      check("join SDA cd R8", cdSdaL, bpSda & cdSda);
      check("join SCL bp R8", bpSclL, bpScl & cdScl);
      check("join SCL cd R8", cdSclL, bpScl & cdScl);
      cyc(1);
    end
    {cdScl, cdSda, bpScl, bpSda} = 4'hF;

    // supply loss: enables drop in the same cycle
    cyc(1);
    sg2 = 1'b0;
    #1;
    check("connect drops same cycle R9", connectEn, 0);
    check("accel drops same cycle R9", accelEn, 0);
    cdSda = 1'b0; #1;
    check("sides split after loss R8", bpSdaL, 1);
    cdSda = 1'b1;
    cyc(1);
    check("lockout after loss R9", phase, 0);

    // idle path with a glitch that restarts the count
    sg2 = 1'b1;
    cyc(1);
    check("rewait R2", phase, 1);
    cyc(500);
    bpScl = 1'b0;
    cyc(1);
    bpScl = 1'b1;
    cyc(600);
    check("glitch restarted idle R5", phase, 1);
    cyc(420);
    check("idle reached R5", phase, 3);
    check("joined after idle R7", connectEn, 1);

    cyc(3);
    finish_run();
  end
endmodule